// File: doc/BRIEF.md
# MSI Doorbell Interrupt Capture Controller

This block sits on the inbound memory-write path of a PCIe root port and turns message-signalled interrupts into one level-sensitive interrupt line for the host CPU. Software chooses a 64-bit doorbell address and a set of enabled vectors through a 32-bit register port. The block watches every inbound request. When a full, aligned 32-bit write lands on the doorbell while capture is active, the block consumes the write. The written data is taken as a vector number, and the matching pending bit is latched. Every other request flows on to the downstream memory path unchanged.

Pending bits are cleared by software writing ones to the pending register, which flips the addressed bits. A mask register gates which pending bits drive the interrupt line. The inbound and downstream paths are valid/ready streams. A captured write is accepted at once and never appears downstream. A forwarded request sees exactly the downstream back-pressure. The register port is a plain single-cycle write strobe plus a read strobe with a registered read return.

Top module: `msi_capture_ctrl`

## Requirements
- R1: After reset the doorbell address, the enable register, the mask register and the pending register all read 0, and `irq` is low.
- R2: Register offsets are: 0x820 doorbell address bits 31:0, 0x824 doorbell address bits 63:32, 0x828 enable, 0x82C mask, 0x830 pending. A read strobe returns `reg_rdata` with `reg_rvalid` high on the next cycle. Any other offset reads 0, and writes to it change nothing.
- R3: A write to either doorbell address register replaces only that 32-bit half and leaves the other half unchanged.
- R4: An inbound write is captured when all of these hold: `in_write` is 1, `in_addr` equals the doorbell address, `in_addr[1:0]` is 0, `in_strb` is 4'hF, and the enable register is nonzero. When captured with data v < 32 and enable bit v set, pending bit v is set on that clock edge. A captured write is accepted (`in_ready` high) and not forwarded (`out_valid` low).
- R5: A captured write whose vector v has enable bit v clear is consumed and leaves the pending register unchanged.
- R6: A captured write whose data is 32 or more is consumed and sets no pending bit.
- R7: While the enable register is zero, writes to the doorbell address are forwarded downstream as ordinary writes.
- R8: A write to the doorbell address with a partial byte strobe, or to a doorbell address whose bits 1:0 are not 0, is forwarded and not captured.
- R9: Reads (`in_write` = 0) to the doorbell address are forwarded downstream like any other request.
- R10: `irq` is high exactly when (pending & ~mask) is nonzero. It follows the registered state with no extra delay.
- R11: A write to the pending register flips each pending bit where the written data is 1. Writing 1 to a clear bit sets it.
- R12: If a capture and a pending-register write address the same bit in the same cycle, the bit ends set.
- R13: A forwarded request has `out_valid` equal to `in_valid`, `in_ready` equal to `out_ready`, and address, data, strobe and direction passed through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| reg_rvalid | output | 1 | Read data valid, one cycle after `reg_rd` |
| in_valid | input | 1 | Inbound request valid |
| in_ready | output | 1 | Inbound request accepted |
| in_write | input | 1 | Inbound request is a write |
| in_addr | input | 64 | Inbound byte address |
| in_data | input | 32 | Inbound write data |
| in_strb | input | 4 | Inbound byte strobes |
| out_valid | output | 1 | Downstream request valid |
| out_ready | input | 1 | Downstream ready |
| out_write | output | 1 | Downstream request is a write |
| out_addr | output | 64 | Downstream byte address |
| out_data | output | 32 | Downstream write data |
| out_strb | output | 4 | Downstream byte strobes |
| irq | output | 1 | Level interrupt to the CPU |

## Verification
Capture and forward decisions (`in_ready`, `out_valid` and the passed-through fields) are combinational. The bench therefore samples them in the same cycle it drives the request, a few time units after the falling edge and before the next rising edge. Register writes and captures take effect on the rising edge that follows. `irq` is sampled at the next falling edge, because it follows the registered pending and mask state directly. Read data is registered, so each read is checked one full cycle after its strobe, at the falling edge where `reg_rvalid` is high.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;
  localparam int OFF_ADDR   = 'h820;
  localparam int OFF_ENABLE = 'h828;
  localparam int OFF_MASK   = 'h82C;
  localparam int OFF_PEND   = 'h830;
endpackage

// File: rtl/msi_cap_regs.sv
module msi_cap_regs
  import msi_cap_pkg::*;
#(
  parameter int REG_AW = 12,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] pend_q,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              reg_rvalid,
  output logic [ADDR_W-1:0] bell_addr,
  output logic [DATA_W-1:0] enable_q,
  output logic [DATA_W-1:0] mask_q,
  output logic              pend_wr,
  output logic [DATA_W-1:0] pend_wdata
);
  localparam int NWORD = ADDR_W / DATA_W;
  localparam int BYTES = DATA_W / 8;

  logic [NWORD-1:0]  word_sel;
  logic              en_sel, mask_sel, pend_sel;
  logic [DATA_W-1:0] rd_word;

  assign en_sel   = reg_addr == REG_AW'(OFF_ENABLE);
  assign mask_sel = reg_addr == REG_AW'(OFF_MASK);
  assign pend_sel = reg_addr == REG_AW'(OFF_PEND);

  // one register per doorbell address word
  for (genvar gi = 0; gi < NWORD; gi++) begin : g_word
    assign word_sel[gi] = reg_addr == REG_AW'(OFF_ADDR + gi * BYTES);
    always_ff @(posedge clk) begin
      if (!rst_n)
        bell_addr[gi*DATA_W +: DATA_W] <= '0;
      else if (reg_wr && word_sel[gi])
        bell_addr[gi*DATA_W +: DATA_W] <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable_q <= '0;
      mask_q   <= '0;
    end else if (reg_wr) begin
      if (en_sel)   enable_q <= reg_wdata;
      if (mask_sel) mask_q   <= reg_wdata;
    end
  end

  assign pend_wr    = reg_wr && pend_sel;
  assign pend_wdata = reg_wdata;

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NWORD; i++)
      if (word_sel[i]) rd_word = bell_addr[i*DATA_W +: DATA_W];
    if (en_sel)   rd_word = enable_q;
    if (mask_sel) rd_word = mask_q;
    if (pend_sel) rd_word = pend_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= reg_rd;
      if (reg_rd) reg_rdata <= rd_word;
    end
  end

  p_rvalid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_rvalid);

  if (NWORD > 1) begin : g_half_chk
    // R3: writing the low word leaves the upper words untouched
    p_low_keeps_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && word_sel[0]) |=> $stable(bell_addr[ADDR_W-1:DATA_W]));
  end
endmodule

// File: rtl/msi_cap_match.sv
module msi_cap_match #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        bell_addr,
  input  logic [DATA_W-1:0]        enable_q,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic                     in_write,
  input  logic [ADDR_W-1:0]        in_addr,
  input  logic [DATA_W-1:0]        in_data,
  input  logic [DATA_W/8-1:0]      in_strb,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic                     out_write,
  output logic [ADDR_W-1:0]        out_addr,
  output logic [DATA_W-1:0]        out_data,
  output logic [DATA_W/8-1:0]      out_strb,
  output logic                     cap_fire,
  output logic [$clog2(DATA_W)-1:0] cap_vec,
  output logic                     cap_in_range
);
  localparam int STRB_W  = DATA_W / 8;
  localparam int ALIGN_W = $clog2(STRB_W);
  localparam int VEC_W   = $clog2(DATA_W);

  logic addr_hit, full_word, armed, hit;

  assign addr_hit  = (in_addr == bell_addr) && (in_addr[ALIGN_W-1:0] == '0);
  assign full_word = &in_strb;
  assign armed     = |enable_q;
  assign hit       = in_write && addr_hit && full_word && armed;

  assign cap_fire     = in_valid && hit;
  assign cap_vec      = in_data[VEC_W-1:0];
  assign cap_in_range = (in_data >> VEC_W) == '0;

  assign out_valid = in_valid && !hit;
  assign in_ready  = hit || out_ready;
  assign out_write = in_write;
  assign out_addr  = in_addr;
  assign out_data  = in_data;
  assign out_strb  = in_strb;

  p_idle_forward_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && enable_q == '0) |-> out_valid);
  p_read_forward_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_write) |-> out_valid);
  p_backpressure_r13: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (in_ready == out_ready));
endmodule

// File: rtl/msi_cap_pend.sv
module msi_cap_pend #(
  parameter int DATA_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cap_fire,
  input  logic [$clog2(DATA_W)-1:0] cap_vec,
  input  logic                      cap_in_range,
  input  logic [DATA_W-1:0]         enable_q,
  input  logic [DATA_W-1:0]         mask_q,
  input  logic                      pend_wr,
  input  logic [DATA_W-1:0]         pend_wdata,
  output logic [DATA_W-1:0]         pend_q,
  output logic                      irq
);
  localparam int VEC_W = $clog2(DATA_W);

  logic [DATA_W-1:0] set_bit, pend_d;

  for (genvar gi = 0; gi < DATA_W; gi++) begin : g_bit
    assign set_bit[gi] = cap_fire && cap_in_range &&
                         (cap_vec == VEC_W'(gi)) && enable_q[gi];
    // toggle first, capture ORed last so a new event is never lost
    assign pend_d[gi]  = (pend_wr ? (pend_q[gi] ^ pend_wdata[gi]) : pend_q[gi])
                         | set_bit[gi];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign irq = |(pend_q & ~mask_q);

  p_set_needs_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pend_wr) |-> ((pend_q & ~$past(pend_q) & ~$past(enable_q)) == '0));
  p_one_vector_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pend_wr) |-> ($countones(pend_q & ~$past(pend_q)) <= 1));
  p_quiet_when_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q == '0) |-> !irq);
endmodule

// File: rtl/msi_capture_ctrl.sv
module msi_capture_ctrl #(
  parameter int REG_AW = 12,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [REG_AW-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic                reg_rvalid,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic                in_write,
  input  logic [ADDR_W-1:0]   in_addr,
  input  logic [DATA_W-1:0]   in_data,
  input  logic [DATA_W/8-1:0] in_strb,
  output logic                out_valid,
  input  logic                out_ready,
  output logic                out_write,
  output logic [ADDR_W-1:0]   out_addr,
  output logic [DATA_W-1:0]   out_data,
  output logic [DATA_W/8-1:0] out_strb,
  output logic                irq
);
  localparam int VEC_W = $clog2(DATA_W);

  logic [ADDR_W-1:0] bell_addr;
  logic [DATA_W-1:0] enable_q, mask_q, pend_q, pend_wdata;
  logic              pend_wr, cap_fire, cap_in_range;
  logic [VEC_W-1:0]  cap_vec;

  msi_cap_regs #(.REG_AW(REG_AW), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .pend_q(pend_q),
    .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid), .bell_addr(bell_addr),
    .enable_q(enable_q), .mask_q(mask_q), .pend_wr(pend_wr),
    .pend_wdata(pend_wdata)
  );

  msi_cap_match #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_match (
    .clk(clk), .rst_n(rst_n), .bell_addr(bell_addr), .enable_q(enable_q),
    .in_valid(in_valid), .in_ready(in_ready), .in_write(in_write),
    .in_addr(in_addr), .in_data(in_data), .in_strb(in_strb),
    .out_valid(out_valid), .out_ready(out_ready), .out_write(out_write),
    .out_addr(out_addr), .out_data(out_data), .out_strb(out_strb),
    .cap_fire(cap_fire), .cap_vec(cap_vec), .cap_in_range(cap_in_range)
  );

  msi_cap_pend #(.DATA_W(DATA_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .cap_fire(cap_fire), .cap_vec(cap_vec),
    .cap_in_range(cap_in_range), .enable_q(enable_q), .mask_q(mask_q),
    .pend_wr(pend_wr), .pend_wdata(pend_wdata), .pend_q(pend_q), .irq(irq)
  );

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!irq && bell_addr == '0 && enable_q == '0));
endmodule

// File: tb/msi_capture_ctrl_tb_top.sv
module msi_capture_ctrl_tb_top;
  localparam int CLK_P = 10;
  localparam logic [63:0] BELL = 64'h0000_00AB_FEE0_0080;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_MSI = 2'd2, OP_IRQ = 2'd3;
  localparam int NV = 47;
  // {op, requirement, reg offset, data, expected}
  localparam logic [81:0] TBL [NV] = '{
    {OP_RD,  4'd1,  12'h820, 32'h0,        32'h0},        // R1
    {OP_RD,  4'd1,  12'h828, 32'h0,        32'h0},        // R1
    {OP_RD,  4'd1,  12'h830, 32'h0,        32'h0},        // R1
    {OP_IRQ, 4'd1,  12'h000, 32'h0,        32'h0},        // R1
    {OP_WR,  4'd2,  12'h820, 32'hFEE00040, 32'h0},
    {OP_WR,  4'd2,  12'h824, 32'h000000AB, 32'h0},
    {OP_RD,  4'd2,  12'h820, 32'h0,        32'hFEE00040}, // R2
    {OP_RD,  4'd2,  12'h824, 32'h0,        32'h000000AB}, // R2
    {OP_WR,  4'd3,  12'h820, 32'hFEE00080, 32'h0},
    {OP_RD,  4'd3,  12'h824, 32'h0,        32'h000000AB}, // R3
    {OP_RD,  4'd3,  12'h820, 32'h0,        32'hFEE00080}, // R3
    {OP_WR,  4'd3,  12'h824, 32'h000000AB, 32'h0},
    {OP_MSI, 4'd7,  12'h000, 32'd5,        32'h0},        // R7 forwarded
    {OP_RD,  4'd7,  12'h830, 32'h0,        32'h0},        // R7
    {OP_WR,  4'd2,  12'h828, 32'h800000FF, 32'h0},
    {OP_RD,  4'd2,  12'h828, 32'h0,        32'h800000FF}, // R2
    {OP_MSI, 4'd4,  12'h000, 32'd5,        32'h1},        // R4
    {OP_RD,  4'd4,  12'h830, 32'h0,        32'h00000020}, // R4
    {OP_IRQ, 4'd10, 12'h000, 32'h0,        32'h1},        // R10
    {OP_MSI, 4'd5,  12'h000, 32'd9,        32'h1},        // R5
    {OP_RD,  4'd5,  12'h830, 32'h0,        32'h00000020}, // R5
    {OP_MSI, 4'd6,  12'h000, 32'd40,       32'h1},        // R6
    {OP_MSI, 4'd6,  12'h000, 32'd32,       32'h1},        // R6
    {OP_RD,  4'd6,  12'h830, 32'h0,        32'h00000020}, // R6
    {OP_MSI, 4'd4,  12'h000, 32'd31,       32'h1},        // R4
    {OP_RD,  4'd4,  12'h830, 32'h0,        32'h80000020}, // R4
    {OP_WR,  4'd10, 12'h82C, 32'h80000020, 32'h0},
    {OP_IRQ, 4'd10, 12'h000, 32'h0,        32'h0},        // R10
    {OP_RD,  4'd2,  12'h82C, 32'h0,        32'h80000020}, // R2
    {OP_WR,  4'd10, 12'h82C, 32'h80000000, 32'h0},
    {OP_IRQ, 4'd10, 12'h000, 32'h0,        32'h1},        // R10
    {OP_WR,  4'd11, 12'h830, 32'h00000020, 32'h0},
    {OP_RD,  4'd11, 12'h830, 32'h0,        32'h80000000}, // R11
    {OP_IRQ, 4'd10, 12'h000, 32'h0,        32'h0},        // R10
    {OP_WR,  4'd10, 12'h82C, 32'h0,        32'h0},
    {OP_IRQ, 4'd10, 12'h000, 32'h0,        32'h1},        // R10
    {OP_WR,  4'd11, 12'h830, 32'h80000000, 32'h0},
    {OP_RD,  4'd11, 12'h830, 32'h0,        32'h0},        // R11
    {OP_IRQ, 4'd11, 12'h000, 32'h0,        32'h0},        // R11
    {OP_WR,  4'd11, 12'h830, 32'h00000001, 32'h0},
    {OP_RD,  4'd11, 12'h830, 32'h0,        32'h00000001}, // R11 flip sets
    {OP_WR,  4'd11, 12'h830, 32'h00000001, 32'h0},
    {OP_RD,  4'd11, 12'h830, 32'h0,        32'h0},        // R11
    {OP_RD,  4'd2,  12'h710, 32'h0,        32'h0},        // R2 unmapped
    {OP_WR,  4'd2,  12'h900, 32'hFFFFFFFF, 32'h0},
    {OP_RD,  4'd2,  12'h900, 32'h0,        32'h0},        // R2
    {OP_RD,  4'd2,  12'h828, 32'h0,        32'h800000FF}  // R2 unchanged
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        reg_rvalid;
  logic        in_valid = 1'b0, in_write = 1'b0, out_ready = 1'b1;
  logic [63:0] in_addr = '0, out_addr;
  logic [31:0] in_data = '0, out_data;
  logic [3:0]  in_strb = '0, out_strb;
  logic        in_ready, out_valid, out_write, irq;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  msi_capture_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .in_valid(in_valid), .in_ready(in_ready),
    .in_write(in_write), .in_addr(in_addr), .in_data(in_data),
    .in_strb(in_strb), .out_valid(out_valid), .out_ready(out_ready),
    .out_write(out_write), .out_addr(out_addr), .out_data(out_data),
    .out_strb(out_strb), .irq(irq)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic do_rd(input string tag, input logic [11:0] a, input logic [31:0] e);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0;
    check({tag, " rvalid"}, 64'(reg_rvalid), 64'd1);
    check(tag, 64'(reg_rdata), 64'(e));
  endtask

  // drive one inbound request; expect capture (consumed) or forward
  task automatic do_in(input string tag, input logic wr, input logic [63:0] a,
                       input logic [31:0] d, input logic [3:0] s, input logic cap);
    @(negedge clk);
    in_valid = 1'b1; in_write = wr; in_addr = a; in_data = d; in_strb = s;
    #1;
    check(tag, {62'd0, out_valid, in_ready}, cap ? 64'b01 : {62'd0, 1'b1, out_ready});
    @(negedge clk); in_valid = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 irq after reset", 64'(irq), 64'd0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;  logic [3:0] rq; logic [11:0] a;
      logic [31:0] d, e;
      string       tag;
      {op, rq, a, d, e} = TBL[i];
      tag = $sformatf("R%0d row %0d", rq, i);
      case (op)
        OP_WR:  do_wr(a, d);
        OP_RD:  do_rd(tag, a, e);
        OP_MSI: do_in(tag, 1'b1, BELL, d, 4'hF, e[0]);
        default: begin @(negedge clk); check(tag, 64'(irq), 64'(e[0])); end
      endcase
    end

    // R13: forwarded fields pass through unchanged
    @(negedge clk);
    in_valid = 1'b1; in_write = 1'b1; in_addr = 64'h1234_5678_9ABC_DEF0;
    in_data = 32'hCAFE_F00D; in_strb = 4'h6; #1;
    check("R13 out_addr", out_addr, 64'h1234_5678_9ABC_DEF0);
    check("R13 out_data/strb/write", {27'd0, out_write, out_strb, out_data},
          {27'd0, 1'b1, 4'h6, 32'hCAFE_F00D});
    @(negedge clk); in_valid = 1'b0;

    // R8: partial strobe and unaligned doorbell are forwarded
    do_in("R8 partial strobe", 1'b1, BELL, 32'd2, 4'h7, 1'b0);
    do_wr(12'h820, 32'hFEE00082);
    do_in("R8 unaligned bell", 1'b1, {BELL[63:32], 32'hFEE00082}, 32'd2, 4'hF, 1'b0);
    do_wr(12'h820, 32'hFEE00080);
    do_rd("R8 pending untouched", 12'h830, 32'h0);

    // R9: reads to the doorbell are forwarded
    do_in("R9 read forwarded", 1'b0, BELL, 32'd3, 4'hF, 1'b0);

    // R13: back-pressure on forwarded, none on captured
    out_ready = 1'b0;
    do_in("R13 stalled forward", 1'b1, 64'h40, 32'd1, 4'hF, 1'b0);
    do_in("R13 capture under stall", 1'b1, BELL, 32'd1, 4'hF, 1'b1);
    out_ready = 1'b1;
    do_rd("R4 bit1 set", 12'h830, 32'h2);

    // R12: capture and clearing write on the same bit, same cycle
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 12'h830; reg_wdata = 32'h2;
    in_valid = 1'b1; in_write = 1'b1; in_addr = BELL; in_data = 32'd1; in_strb = 4'hF;
    @(negedge clk);
    reg_wr = 1'b0; in_valid = 1'b0;
    do_rd("R12 capture wins", 12'h830, 32'h2);
    @(negedge clk);
    check("R12 irq held", 64'(irq), 64'd1);

    // R1: reset in mid-run clears all state
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    check("R1 irq after second reset", 64'(irq), 64'd0);
    do_rd("R1 addr lo", 12'h820, 32'h0);
    do_rd("R1 addr hi", 12'h824, 32'h0);
    do_rd("R1 mask", 12'h82C, 32'h0);
    do_rd("R1 pending", 12'h830, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule